// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block turns single requests from a 16-bit processor core into external bus cycles on one shared group of lines. The same lines first carry a 20-bit address and then 16 bits of data. The core presents a physical address, a memory or I/O select, a read or write direction, a byte or word size and write data. The controller then runs a fixed sequence of clocks: an address phase, a strobe phase, a ready-sampling phase with optional wait clocks, and a closing phase. It drives an address-latch strobe, read and write strobes, a memory/IO indicator and two byte enables. It hands read data and a one-clock acknowledge back to the core.

The external lines are split into an output vector, an output enable and an input vector, so a pad ring or a test environment can form the shared group. A word request at an odd address is refused with a one-clock error pulse. No bus cycle is started for it. Requests are taken only while the bus is idle.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset the block is idle: `bus_idle` is 1, and `ale`, `rd_stb`, `wr_stb`, `req_ack`, `req_err` and `ad_oe` are all 0.
- R2: The clock after a request is accepted (T1), `ale` is high for exactly that one clock, `ad_oe` is 1, `ad_out` carries the full 20-bit address, and for a memory request `mem_sel` is 1.
- R3: For an I/O request (`req_io`=1), `mem_sel` is 0 for the whole cycle, and in T1 `ad_out[19:16]` is 0 while `ad_out[15:0]` holds the low 16 address bits.
- R4: On a read, `rd_stb` is high from the second clock through the last ready-sampling clock and `ad_oe` is 0 in those clocks. On a write, `wr_stb` is high over the same clocks and `ad_oe` is 1 with the write data on `ad_out[15:0]`.
- R5: A cycle with `bus_ready` high at the end of its third clock lasts exactly four clocks, counted from the `ale` clock through the `req_ack` clock inclusive.
- R6: Each low sample of `bus_ready` at the end of the third clock or of a wait clock adds one wait clock, with the strobe held.
- R7: Read data is taken from `ad_in` at the end of the final ready-sampling clock and is valid on `rsp_rdata` with `req_ack`. A word read returns `ad_in` unchanged. A byte read returns the addressed lane zero-extended: bits [7:0] for an even address and bits [15:8] for an odd address.
- R8: Byte enables are active high. `be[0]` selects lane [7:0] and is set for a word or an even byte. `be[1]` selects lane [15:8] and is set for a word or an odd byte. A byte write places `req_wdata[7:0]` on both lanes.
- R9: `req_ack` is high for exactly one clock, the fourth phase (T4), and `rd_stb` and `wr_stb` are both low in that clock.
- R10: A word request at an odd address raises `req_err` for one clock in the cycle after it is seen. It produces no `ale` and no `req_ack`, and the block stays idle.
- R11: `bus_idle` is 0 from T1 through T4, and a request presented while the bus is busy is ignored: it neither changes the running cycle's address nor starts a second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present |
| req_addr | input | 20 | Physical address |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_wdata | input | 16 | Write data (byte in bits [7:0]) |
| req_ack | output | 1 | One-clock completion pulse |
| req_err | output | 1 | One-clock misaligned-word refusal |
| rsp_rdata | output | 16 | Read data, valid with req_ack |
| bus_ready | input | 1 | External ready, sampled in T3 and wait clocks |
| ad_in | input | 16 | Shared lines, input side |
| ad_out | output | 20 | Shared lines, output side |
| ad_oe | output | 1 | Output enable for the shared lines |
| ale | output | 1 | Address-latch strobe |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| mem_sel | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| be | output | 2 | Byte-lane enables, active high |
| bus_idle | output | 1 | No bus cycle in progress |

## Verification
The main function is tried with a memory word read, byte reads at even and at odd addresses, an I/O byte write and a memory word write.
- The two byte reads separate the lane selection in both the enables and the returned data.
- The word read and the word write separate read steering from write steering.
- The I/O write, at an address with high bits set, exposes an address that is not cut to 16 bits or a wrong memory/IO indicator.
- A cycle with two wait clocks tells a correct ready loop from one that ignores ready or counts it wrongly.
- A misaligned word request and a request held during a busy cycle show whether refusal and busy-masking leak into a bus cycle.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
    parameter int ADDR_W = 20;
    parameter int DATA_W = 16;
    parameter int IO_W   = 16;
    parameter int LANE_W = 8;
    localparam int LANES = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        PH_IDLE, PH_T1, PH_T2, PH_T3, PH_TW, PH_T4
    } phase_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              io;
        logic              write;
        logic              word;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [LANES-1:0] lane_enables(input logic a0, input logic word);
        logic [LANES-1:0] e;
        if (word) e = '1;
        else      e = a0 ? LANES'(2'b10) : LANES'(2'b01);
        return e;
    endfunction

    function automatic logic misaligned(input logic a0, input logic word);
        return word & a0;
    endfunction

    function automatic logic strobe_phase(input phase_e p);
        return (p == PH_T2) || (p == PH_T3) || (p == PH_TW);
    endfunction
endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
    import mbc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   ready,
    output phase_e phase,
    output logic   capture
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
        end else begin
            case (phase)
                PH_IDLE: if (start) phase <= PH_T1;
                PH_T1:   phase <= PH_T2;
                PH_T2:   phase <= PH_T3;
                PH_T3,
                PH_TW:   phase <= ready ? PH_T4 : PH_TW;
                PH_T4:   phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign capture = ((phase == PH_T3) || (phase == PH_TW)) && ready;
endmodule

// File: rtl/mbc_lanes.sv
module mbc_lanes
    import mbc_pkg::*;
(
    input  bus_req_t           req,
    input  phase_e             phase,
    input  logic [DATA_W-1:0]  ad_in,
    output logic [ADDR_W-1:0]  ad_out,
    output logic               ad_oe,
    output logic [LANES-1:0]   be,
    output logic [DATA_W-1:0]  rd_data
);
    logic [DATA_W-1:0] wr_lanes;
    logic [ADDR_W-1:0] addr_drive;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wr_lanes[i*LANE_W +: LANE_W] =
            req.word ? req.wdata[i*LANE_W +: LANE_W] : req.wdata[LANE_W-1:0];
    end

    assign addr_drive = req.io ? {{(ADDR_W-IO_W){1'b0}}, req.addr[IO_W-1:0]} : req.addr;

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        if (phase == PH_T1) begin
            ad_out = addr_drive;
            ad_oe  = 1'b1;
        end else if (req.write && strobe_phase(phase)) begin
            ad_out = {{(ADDR_W-DATA_W){1'b0}}, wr_lanes};
            ad_oe  = 1'b1;
        end
    end

    assign be = (phase == PH_IDLE) ? '0 : lane_enables(req.addr[0], req.word);

    always_comb begin
        if (req.word)
            rd_data = ad_in;
        else if (req.addr[0])
            rd_data = {{(DATA_W-LANE_W){1'b0}}, ad_in[DATA_W-1 -: LANE_W]};
        else
            rd_data = {{(DATA_W-LANE_W){1'b0}}, ad_in[LANE_W-1:0]};
    end
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
    import mbc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [19:0]       req_addr,
    input  logic              req_io,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [15:0]       req_wdata,
    output logic              req_ack,
    output logic              req_err,
    output logic [15:0]       rsp_rdata,
    input  logic              bus_ready,
    input  logic [15:0]       ad_in,
    output logic [19:0]       ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              rd_stb,
    output logic              wr_stb,
    output logic              mem_sel,
    output logic [1:0]        be,
    output logic              bus_idle
);
    phase_e            phase;
    logic              capture;
    logic              start;
    logic              bad;
    bus_req_t          req_q;
    logic [DATA_W-1:0] rd_data;

    assign bus_idle = (phase == PH_IDLE);
    assign bad      = misaligned(req_addr[0], req_word);
    assign start    = bus_idle && req_valid && !bad;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q     <= '0;
            req_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            req_err <= bus_idle && req_valid && bad;
            if (start) begin
                req_q.addr  <= req_addr;
                req_q.io    <= req_io;
                req_q.write <= req_write;
                req_q.word  <= req_word;
                req_q.wdata <= req_wdata;
            end
            if (capture && !req_q.write)
                rsp_rdata <= rd_data;
        end
    end

    mbc_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ready   (bus_ready),
        .phase   (phase),
        .capture (capture)
    );

    mbc_lanes u_lanes (
        .req     (req_q),
        .phase   (phase),
        .ad_in   (ad_in),
        .ad_out  (ad_out),
        .ad_oe   (ad_oe),
        .be      (be),
        .rd_data (rd_data)
    );

    assign ale     = (phase == PH_T1);
    assign rd_stb  = !req_q.write && strobe_phase(phase);
    assign wr_stb  =  req_q.write && strobe_phase(phase);
    assign req_ack = (phase == PH_T4);
    assign mem_sel = !bus_idle && !req_q.io;
endmodule

// File: rtl/mux_bus_ctrl_chk.sv
module mux_bus_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic ale,
    input logic rd_stb,
    input logic wr_stb,
    input logic req_ack,
    input logic req_err,
    input logic bus_idle,
    input logic mem_sel
);
    assert_ale_single_R2: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(rd_stb && wr_stb));

    assert_ack_single_R9: assert property (@(posedge clk) disable iff (rst)
        req_ack |=> !req_ack);

    assert_ack_no_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> (!rd_stb && !wr_stb));

    assert_ack_after_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ack) |-> $past(rd_stb || wr_stb));

    assert_err_no_cycle_R10: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (bus_idle && !ale && !req_ack));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        bus_idle |-> (!ale && !rd_stb && !wr_stb && !req_ack));

    assert_space_stable_R3: assert property (@(posedge clk) disable iff (rst)
        (!bus_idle && !ale) |-> $stable(mem_sel));
endmodule

bind mux_bus_ctrl mux_bus_ctrl_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ale      (ale),
    .rd_stb   (rd_stb),
    .wr_stb   (wr_stb),
    .req_ack  (req_ack),
    .req_err  (req_err),
    .bus_idle (bus_idle),
    .mem_sel  (mem_sel)
);

// File: tb/mux_bus_ctrl_tb.sv
`timescale 1ns/1ps
module mux_bus_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [19:0] req_addr;
    logic        req_io, req_write, req_word;
    logic [15:0] req_wdata;
    logic        req_ack, req_err;
    logic [15:0] rsp_rdata;
    logic        bus_ready;
    logic [15:0] ad_in;
    logic [19:0] ad_out;
    logic        ad_oe, ale, rd_stb, wr_stb, mem_sel, bus_idle;
    logic [1:0]  be;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // observations of the latest bus cycle
    logic [19:0] o_addr;
    logic        o_mio;
    logic        o_mio_bad;
    logic [1:0]  o_be;
    logic [19:0] o_wdata;
    logic        o_wr_oe;
    logic        o_rd_oe;
    logic [15:0] o_rdata;
    int          o_cycles, o_ales, o_acks, o_rd_cnt, o_wr_cnt;
    logic        o_ack_strobe;

    always #2 clk = ~clk;

    mux_bus_ctrl u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_io(req_io), .req_write(req_write), .req_word(req_word),
        .req_wdata(req_wdata), .req_ack(req_ack), .req_err(req_err),
        .rsp_rdata(rsp_rdata), .bus_ready(bus_ready), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .mem_sel(mem_sel), .be(be), .bus_idle(bus_idle)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Runs one request; bus_ready is raised once 2+waits strobe clocks were seen.
    task automatic run_cycle(input logic [19:0] a, input bit io, input bit wr, input bit wd,
                             input logic [15:0] wdat, input int waits, input logic [15:0] bus_val,
                             input bit hold_busy);
        int strobes = 0;
        bit started = 0;
        o_cycles = 0; o_ales = 0; o_acks = 0; o_rd_cnt = 0; o_wr_cnt = 0;
        o_rd_oe = 0; o_wr_oe = 1; o_ack_strobe = 0; o_mio_bad = 0;
        o_addr = '0; o_mio = 0; o_be = '0; o_wdata = '0; o_rdata = '0;
        ad_in = bus_val;
        bus_ready = 0;
        @(negedge clk);
        req_valid = 1; req_addr = a; req_io = io; req_write = wr; req_word = wd; req_wdata = wdat;
        @(negedge clk);
        if (hold_busy) req_addr = a ^ 20'h00F00;
        else req_valid = 0;
        for (int k = 0; k < 40; k++) begin
            if (ale) begin
                o_ales++;
                o_addr = ad_out; o_mio = mem_sel; o_be = be;
                started = 1;
            end
            if (started) begin
                o_cycles++;
                if (mem_sel != o_mio) o_mio_bad = 1;
            end
            if (rd_stb || wr_stb) begin
                strobes++;
                if (rd_stb) begin o_rd_cnt++; if (ad_oe) o_rd_oe = 1; end
                if (wr_stb) begin o_wr_cnt++; o_wdata = ad_out; if (!ad_oe) o_wr_oe = 0; end
            end
            bus_ready = (strobes >= 2 + waits);
            if (req_ack) begin
                o_acks++;
                o_rdata = rsp_rdata;
                o_ack_strobe = rd_stb | wr_stb;
                req_valid = 0;
                break;
            end
            @(negedge clk);
        end
        bus_ready = 0;
        // watch the following clocks for anything spurious
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (ale) o_ales++;
            if (req_ack) o_acks++;
        end
    endtask

    task automatic t_reset;
        rst = 1; req_valid = 0; req_addr = '0; req_io = 0; req_write = 0; req_word = 0;
        req_wdata = '0; bus_ready = 0; ad_in = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(bus_idle && !ale && !rd_stb && !wr_stb && !req_ack && !req_err && !ad_oe,
            "R1 idle after reset",
            {26'd0, bus_idle, ale, rd_stb, wr_stb, req_ack, ad_oe}, 32'h20);
    endtask

    task automatic t_word_read;
        run_cycle(20'hABCDE & 20'hFFFFE, 0, 0, 1, 16'h0, 0, 16'h5AC3, 0);
        chk(o_addr == 20'hABCDE && o_mio, "R2 T1 address and memory select", {11'd0, o_mio, o_addr}, {11'd0, 1'b1, 20'hABCDE});
        chk(o_cycles == 4, "R5 four-clock cycle", o_cycles, 4);
        chk(o_rd_cnt == 2 && !o_rd_oe, "R4 read strobe with lines released", {o_rd_cnt[15:0], 15'd0, o_rd_oe}, {16'd2, 16'd0});
        chk(o_rdata == 16'h5AC3, "R7 word read data", o_rdata, 16'h5AC3);
        chk(o_be == 2'b11, "R8 word enables", o_be, 2'b11);
        chk(o_acks == 1 && !o_ack_strobe, "R9 single ack without strobe", {o_acks[15:0], 15'd0, o_ack_strobe}, {16'd1, 16'd0});
    endtask

    task automatic t_byte_reads;
        run_cycle(20'h12345, 0, 0, 0, 16'h0, 0, 16'hA55A, 0);
        chk(o_rdata == 16'h00A5, "R7 odd byte read lane", o_rdata, 16'h00A5);
        chk(o_be == 2'b10, "R8 odd byte enables", o_be, 2'b10);
        run_cycle(20'h12344, 0, 0, 0, 16'h0, 0, 16'hA55A, 0);
        chk(o_rdata == 16'h005A, "R7 even byte read lane", o_rdata, 16'h005A);
        chk(o_be == 2'b01, "R8 even byte enables", o_be, 2'b01);
    endtask

    task automatic t_io_write;
        run_cycle(20'hF1235, 1, 1, 0, 16'h77C3, 0, 16'h0, 0);
        chk(o_addr == 20'h01235, "R3 I/O address uses low 16 bits", o_addr, 20'h01235);
        chk(!o_mio && !o_mio_bad, "R3 I/O indicator held", {o_mio, o_mio_bad}, 2'b00);
        chk(o_wdata == 20'h0C3C3 && o_wr_oe && o_wr_cnt == 2, "R8 byte write on both lanes", o_wdata, 20'h0C3C3);
        chk(o_be == 2'b10, "R8 I/O odd byte enables", o_be, 2'b10);
    endtask

    task automatic t_word_write;
        run_cycle(20'hABCD4, 0, 1, 1, 16'h1234, 0, 16'h0, 0);
        chk(o_wdata == 20'h01234 && o_wr_oe, "R4 word write data driven", o_wdata, 20'h01234);
        chk(o_rd_cnt == 0 && o_wr_cnt == 2, "R4 write strobe only", {o_rd_cnt[15:0], o_wr_cnt[15:0]}, {16'd0, 16'd2});
    endtask

    task automatic t_waits;
        run_cycle(20'h40002, 0, 0, 1, 16'h0, 2, 16'hBEEF, 0);
        chk(o_cycles == 6, "R6 two wait clocks added", o_cycles, 6);
        chk(o_rd_cnt == 4, "R6 strobe held through waits", o_rd_cnt, 4);
        chk(o_rdata == 16'hBEEF, "R7 data after waits", o_rdata, 16'hBEEF);
    endtask

    task automatic t_misaligned;
        bit saw_ale = 0;
        @(negedge clk);
        req_valid = 1; req_addr = 20'h00101; req_word = 1; req_write = 0; req_io = 0;
        @(negedge clk);
        chk(req_err && bus_idle && !ale, "R10 error pulse, no cycle", {req_err, bus_idle, ale}, 3'b110);
        req_valid = 0;
        @(negedge clk);
        chk(!req_err, "R10 error lasts one clock", req_err, 0);
        for (int k = 0; k < 5; k++) begin
            if (ale || req_ack || !bus_idle) saw_ale = 1;
            @(negedge clk);
        end
        chk(!saw_ale, "R10 block stays idle", saw_ale, 0);
    endtask

    task automatic t_busy;
        run_cycle(20'h2468A, 0, 0, 1, 16'h0, 0, 16'h1111, 1);
        chk(o_addr == 20'h2468A, "R11 running address unchanged", o_addr, 20'h2468A);
        chk(o_ales == 1 && o_acks == 1, "R11 busy request ignored", {o_ales[15:0], o_acks[15:0]}, {16'd1, 16'd1});
    endtask

    initial begin
        t_reset();
        t_word_read();
        t_byte_reads();
        t_io_write();
        t_word_write();
        t_waits();
        t_misaligned();
        t_busy();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule